// File: doc/BRIEF.md
# Two-Hop Intermediate Port Selector

In a router where every line card holds a share of the packet buffer, a cell crosses the crossbar twice. It goes first from its input card to an intermediate card that stores it, and later from that card to its output card. This block is the central scheduler that picks the intermediate card for each arriving cell. It handles one request per clock cycle, in arrival order. Each request names the input port, the output port and the departure slot, given as an offset from the current slot. The block answers one cycle later with a chosen port, or with a failure indication.

The choice is made against two sets of usage counters. One set counts, per crossbar edge (input, intermediate), the cells written in the current slot, with a cap of S1. The other is a circular table indexed by future slot. It counts, per edge (intermediate, output), the cells already booked to leave in that slot, with a cap of S2. A slot strobe ends the current slot. It empties the write counters, retires the table row of the slot that just ended, and moves the base of the table on by one. With S1 = S2 = 2, at most N-1 competing cells on each side always leave one eligible port, so a failure points to traffic outside that bound.

Top module: `dsm_hop_selector`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high on the next cycle. `rsp_valid` is low on any cycle that does not follow such a request.
- R2: Port x is eligible only if fewer than S1 cells from `req_src` to x have been granted in the current slot.
- R3: Port x is eligible only if fewer than S2 cells from x to `req_dst` are booked for departure slot (current slot + `req_dep_off`) modulo HORIZON.
- R4: Among the eligible ports, the one with the lowest index is returned on `rsp_port`, with `rsp_fail` low.
- R5: A grant increments the write count of edge (src, x) and the read count of edge (x, dst) in the departure slot. A failed request changes no count.
- R6: `slot_tick` empties every write count. A request in the same cycle is judged against the counts from before the tick.
- R7: `slot_tick` empties the table row of the slot that is ending and advances the current slot by one, wrapping modulo HORIZON. Offsets given after the tick are counted from the new slot.
- R8: When no port is eligible, the response has `rsp_fail` = 1 and `rsp_port` = 0. `ovf_sticky` rises with that response and stays high until reset.
- R9: A cycle with `req_valid` low gives no response and changes no count, whatever the other request inputs carry.
- R10: During reset all counts are emptied, the current slot becomes 0, and `rsp_valid`, `rsp_fail`, `rsp_port` and `ovf_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Ends the current cell slot |
| req_valid | input | 1 | A request is present this cycle |
| req_src | input | $clog2(N) | Input port of the arriving cell |
| req_dst | input | $clog2(N) | Output port of the cell |
| req_dep_off | input | $clog2(HORIZON) | Departure slot, as an offset from the current slot |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | $clog2(N) | Chosen intermediate port, 0 on failure |
| rsp_fail | output | 1 | No port was eligible |
| ovf_sticky | output | 1 | At least one request has failed since reset |

## Verification
Every counter feeds straight into the next decision, so a counter that is off by one shows at the ports within a few requests. It appears either as a port index that moves one step too early or too late along the lowest-index order, or as a premature or missing failure. A table row that is not retired, or a slot pointer that is off, only shows up once the table wraps. That is HORIZON slots later, when a stale booking blocks a port that ought to be free. The stimulus therefore fills edges to their caps on both sides, crosses slot boundaries, and wraps the table back onto a slot that has been cleared.

// File: rtl/dsm_sel_pkg.sv
// Shared definitions for the two-hop intermediate port selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dsm_sel_pkg;

    // Outcome of one request, held in the response register.
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_FAIL  = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/dsm_wr_ledger.sv
// Write-side ledger: one saturating count per crossbar edge (source,
// intermediate) for the current slot. It reports, for the source being
// looked up, which intermediates still have spare write capacity.
// Assumes that an increment is only requested for an edge reported free,
// so no count exceeds CAP. A clear takes priority over an increment.
module dsm_wr_ledger #(
    parameter int N   = 4,
    parameter int CAP = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic [IW-1:0] look_src,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_mid,
    output logic [N-1:0]  free_vec,
    output logic          any_used
);

    logic [CW-1:0] cnt [N][N];

    for (genvar gs = 0; gs < N; gs++) begin : g_src
        for (genvar gx = 0; gx < N; gx++) begin : g_mid
            // Count the writes on edge (gs, gx) during the current slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[gs][gx] <= '0;
                end else if (clear_all) begin
                    cnt[gs][gx] <= '0;
                end else if (inc_en && look_src == IW'(gs) && inc_mid == IW'(gx)) begin
                    cnt[gs][gx] <= cnt[gs][gx] + CW'(1);
                end
            end
        end
    end

    // Report which intermediates have room for the looked-up source.
    always_comb begin
        for (int x = 0; x < N; x++) begin
            free_vec[x] = int'(cnt[look_src][x]) < CAP;
        end
    end

    // Flag whether any edge carries a write in this slot.
    always_comb begin
        any_used = 1'b0;
        for (int s = 0; s < N; s++) begin
            for (int x = 0; x < N; x++) begin
                if (cnt[s][x] != '0) begin
                    any_used = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dsm_rd_ledger.sv
// Read-side ledger: a circular table of HORIZON rows. Each row holds one
// saturating count per edge (intermediate, destination) for a future
// departure slot. The row of the current slot is emptied when the slot
// ends and the base pointer moves on. Assumes HORIZON is a power of two,
// so the offset add wraps by itself, and that increments only target
// edges reported free. A clear takes priority over an increment.
module dsm_rd_ledger #(
    parameter int N       = 4,
    parameter int CAP     = 2,
    parameter int HORIZON = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int HW = (HORIZON > 1) ? $clog2(HORIZON) : 1,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [IW-1:0] look_dst,
    input  logic [HW-1:0] look_off,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_mid,
    output logic [N-1:0]  free_vec
);

    logic [HW-1:0] base_q;
    logic [HW-1:0] row_sel;
    logic [CW-1:0] cnt [HORIZON][N][N];

    // Map the relative offset onto an absolute table row.
    assign row_sel = base_q + look_off;

    // Move the base row forward at each slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (advance) begin
            base_q <= base_q + HW'(1);
        end
    end

    for (genvar gt = 0; gt < HORIZON; gt++) begin : g_row
        for (genvar gx = 0; gx < N; gx++) begin : g_mid
            for (genvar gd = 0; gd < N; gd++) begin : g_dst
                // Count departures booked on edge (gx, gd) in row gt.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cnt[gt][gx][gd] <= '0;
                    end else if (advance && base_q == HW'(gt)) begin
                        cnt[gt][gx][gd] <= '0;
                    end else if (inc_en && row_sel == HW'(gt) &&
                                 inc_mid == IW'(gx) && look_dst == IW'(gd)) begin
                        cnt[gt][gx][gd] <= cnt[gt][gx][gd] + CW'(1);
                    end
                end
            end
        end
    end

    // Report which intermediates can still reach the destination in that row.
    always_comb begin
        for (int x = 0; x < N; x++) begin
            free_vec[x] = int'(cnt[row_sel][x][look_dst]) < CAP;
        end
    end

endmodule

// File: rtl/dsm_low_pick.sv
// Fixed-priority picker: grants the lowest-indexed set bit of the request
// vector and reports its index. It is purely combinational and assumes
// nothing about how many bits are set.
module dsm_low_pick #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_vec,
    output logic [N-1:0]  grant_vec,
    output logic [IW-1:0] grant_idx,
    output logic          found
);

    // Scan upward and stop at the first candidate.
    always_comb begin
        grant_vec = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (req_vec[k] && !found) begin
                grant_vec[k] = 1'b1;
                grant_idx    = IW'(k);
                found        = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsm_hop_selector.sv
// Two-hop intermediate port selector. It takes one request per cycle and
// ANDs write-side and read-side eligibility. It grants the lowest eligible
// intermediate port and books the grant in both ledgers. The response is
// registered, so it appears one cycle after the request. A request that
// arrives with slot_tick is judged against the counts from before the tick.
// Assumes HORIZON is a power of two.
module dsm_hop_selector #(
    parameter int N       = 4,
    parameter int S1      = 2,
    parameter int S2      = 2,
    parameter int HORIZON = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int HW = (HORIZON > 1) ? $clog2(HORIZON) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          req_valid,
    input  logic [IW-1:0] req_src,
    input  logic [IW-1:0] req_dst,
    input  logic [HW-1:0] req_dep_off,
    output logic          rsp_valid,
    output logic [IW-1:0] rsp_port,
    output logic          rsp_fail,
    output logic          ovf_sticky
);

    import dsm_sel_pkg::*;

    logic [N-1:0]  wr_free;
    logic [N-1:0]  rd_free;
    logic [N-1:0]  elig_vec;
    logic [N-1:0]  grant_vec;
    logic [IW-1:0] pick_idx;
    logic          pick_found;
    logic          grant_en;
    logic          wr_any_used;
    rsp_kind_e     kind_d;
    rsp_kind_e     kind_q;
    logic [IW-1:0] port_q;
    logic          ovf_q;

    // A port qualifies only when both crossbar hops have room.
    assign elig_vec = wr_free & rd_free;
    assign grant_en = req_valid & pick_found;

    dsm_wr_ledger #(.N(N), .CAP(S1)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_all(slot_tick),
        .look_src (req_src),
        .inc_en   (grant_en),
        .inc_mid  (pick_idx),
        .free_vec (wr_free),
        .any_used (wr_any_used)
    );

    dsm_rd_ledger #(.N(N), .CAP(S2), .HORIZON(HORIZON)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (slot_tick),
        .look_dst (req_dst),
        .look_off (req_dep_off),
        .inc_en   (grant_en),
        .inc_mid  (pick_idx),
        .free_vec (rd_free)
    );

    dsm_low_pick #(.N(N)) u_pick (
        .req_vec  (elig_vec),
        .grant_vec(grant_vec),
        .grant_idx(pick_idx),
        .found    (pick_found)
    );

    // Classify this cycle's request.
    always_comb begin
        if (!req_valid) begin
            kind_d = RSP_IDLE;
        end else if (pick_found) begin
            kind_d = RSP_GRANT;
        end else begin
            kind_d = RSP_FAIL;
        end
    end

    // Register the response and keep the overflow flag sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RSP_IDLE;
            port_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            kind_q <= kind_d;
            port_q <= (kind_d == RSP_GRANT) ? pick_idx : '0;
            if (kind_d == RSP_FAIL) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign rsp_valid  = (kind_q != RSP_IDLE);
    assign rsp_fail   = (kind_q == RSP_FAIL);
    assign rsp_port   = port_q;
    assign ovf_sticky = ovf_q;

endmodule

// File: rtl/dsm_hop_selector_chk.sv
// Checker for the two-hop intermediate port selector, bound to every
// instance of the top module. Observes ports and the picker/ledger outputs.
module dsm_hop_selector_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_tick,
    input logic          req_valid,
    input logic          rsp_valid,
    input logic [IW-1:0] rsp_port,
    input logic          rsp_fail,
    input logic          ovf_sticky,
    input logic [N-1:0]  grant_vec,
    input logic          pick_found,
    input logic          wr_any_used
);

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R5
    grant_books_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pick_found && !slot_tick) |=> wr_any_used);

    // R6
    tick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !wr_any_used);

    // R8
    fail_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> (rsp_valid && rsp_port == '0 && ovf_sticky));

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

endmodule

bind dsm_hop_selector dsm_hop_selector_chk #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_port   (rsp_port),
    .rsp_fail   (rsp_fail),
    .ovf_sticky (ovf_sticky),
    .grant_vec  (grant_vec),
    .pick_found (pick_found),
    .wr_any_used(wr_any_used)
);

// File: tb/dsm_hop_selector_tb_top.sv
`timescale 1ns/1ps
// Bench for the two-hop selector: a vector table walked in one loop,
// then directed checks on reset and on ignored requests.
module dsm_hop_selector_tb_top;

    localparam int N = 4;
    localparam int H = 8;

    typedef struct packed {
        logic       tick;
        logic       vld;
        logic [1:0] src;
        logic [1:0] dst;
        logic [2:0] off;
        logic       fail;
        logic [1:0] port;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,2'd0,2'd0,3'd1,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd1,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd1,1'b0,2'd1},
        '{1'b0,1'b1,2'd1,2'd0,3'd1,1'b0,2'd1},
        '{1'b0,1'b1,2'd1,2'd0,3'd1,1'b0,2'd2},
        '{1'b0,1'b1,2'd2,2'd1,3'd1,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b0,2'd1},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b0,2'd2},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b0,2'd2},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b0,2'd3},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b0,2'd3},
        '{1'b0,1'b1,2'd0,2'd0,3'd2,1'b1,2'd0},
        '{1'b0,1'b1,2'd1,2'd3,3'd3,1'b0,2'd0},
        '{1'b0,1'b1,2'd2,2'd3,3'd3,1'b0,2'd0},
        '{1'b0,1'b1,2'd3,2'd3,3'd3,1'b0,2'd1},
        '{1'b0,1'b1,2'd3,2'd3,3'd3,1'b0,2'd1},
        '{1'b0,1'b1,2'd3,2'd3,3'd3,1'b0,2'd2},
        '{1'b0,1'b1,2'd2,2'd3,3'd3,1'b0,2'd2},
        '{1'b0,1'b1,2'd2,2'd3,3'd3,1'b0,2'd3},
        '{1'b0,1'b1,2'd1,2'd3,3'd3,1'b0,2'd3},
        '{1'b0,1'b1,2'd1,2'd3,3'd3,1'b1,2'd0},
        '{1'b1,1'b0,2'd0,2'd0,3'd0,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd0,1'b0,2'd2},
        '{1'b0,1'b1,2'd0,2'd0,3'd0,1'b0,2'd3},
        '{1'b0,1'b1,2'd1,2'd0,3'd0,1'b0,2'd3},
        '{1'b0,1'b1,2'd2,2'd0,3'd0,1'b1,2'd0},
        '{1'b1,1'b0,2'd0,2'd0,3'd0,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd7,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd7,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd7,1'b0,2'd1},
        '{1'b1,1'b1,2'd0,2'd0,3'd6,1'b0,2'd1},
        '{1'b0,1'b1,2'd0,2'd0,3'd5,1'b0,2'd0},
        '{1'b0,1'b1,2'd0,2'd0,3'd5,1'b0,2'd0},
        '{1'b0,1'b1,2'd1,2'd0,3'd5,1'b0,2'd1},
        '{1'b0,1'b1,2'd1,2'd0,3'd5,1'b0,2'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_src = '0;
    logic [1:0] req_dst = '0;
    logic [2:0] req_dep_off = '0;
    logic       rsp_valid;
    logic [1:0] rsp_port;
    logic       rsp_fail;
    logic       ovf_sticky;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    dsm_hop_selector #(.N(N), .S1(2), .S2(2), .HORIZON(H)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_tick  (slot_tick),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_dst    (req_dst),
        .req_dep_off(req_dep_off),
        .rsp_valid  (rsp_valid),
        .rsp_port   (rsp_port),
        .rsp_fail   (rsp_fail),
        .ovf_sticky (ovf_sticky)
    );

    // Compare one observed value with its expectation.
    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic tk, input logic v, input logic [1:0] s,
                         input logic [1:0] d, input logic [2:0] o);
        slot_tick   = tk;
        req_valid   = v;
        req_src     = s;
        req_dst     = d;
        req_dep_off = o;
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic ovf_exp;
        ovf_exp = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs during reset
        check("R10 rsp_valid in reset", int'(rsp_valid), 0);
        check("R10 ovf_sticky in reset", int'(ovf_sticky), 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 covered by the vectors.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].tick, VECS[i].vld, VECS[i].src, VECS[i].dst, VECS[i].off);
            @(negedge clk);
            if (VECS[i].vld && VECS[i].fail) ovf_exp = 1'b1;
            check($sformatf("R1 valid v%0d", i), int'(rsp_valid), int'(VECS[i].vld));
            check($sformatf("%s fail v%0d", VECS[i].fail ? "R8" : "R2 R3", i),
                  int'(rsp_fail), int'(VECS[i].fail));
            check($sformatf("%s port v%0d", VECS[i].tick ? "R6 R7" : "R4 R5", i),
                  int'(rsp_port), int'(VECS[i].port));
            check($sformatf("R8 ovf v%0d", i), int'(ovf_sticky), int'(ovf_exp));
        end
        drive(1'b0, 1'b0, 2'd0, 2'd0, 3'd0);
        @(negedge clk);
        check("R8 ovf held", int'(ovf_sticky), 1);

        // R10: reset clears flag and outputs
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 ovf after reset", int'(ovf_sticky), 0);
        check("R10 rsp_valid after reset", int'(rsp_valid), 0);
        check("R10 rsp_port after reset", int'(rsp_port), 0);

        // R9: requests with valid low give nothing and book nothing
        for (int k = 0; k < 2; k++) begin
            drive(1'b0, 1'b0, 2'd0, 2'd0, 3'd1);
            @(negedge clk);
            check("R9 no response", int'(rsp_valid), 0);
        end
        drive(1'b0, 1'b1, 2'd0, 2'd0, 3'd1);
        @(negedge clk);
        check("R9 first grant", int'(rsp_port), 0);
        @(negedge clk);
        check("R9 second grant", int'(rsp_port), 0);
        @(negedge clk);
        check("R9 third grant", int'(rsp_port), 1);
        check("R9 third not failed", int'(rsp_fail), 0);
        drive(1'b0, 1'b0, 2'd0, 2'd0, 3'd0);
        @(negedge clk);
        check("R9 idle after burst", int'(rsp_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule